// File: doc/BRIEF.md
# Mains Zero-Crossing Falling-Edge Debouncer

This block cleans up the one-bit output of a mains zero-crossing comparator before that signal drives a synchronization loop. The comparator already applies hysteresis, so its output is 0 below the lower threshold and 1 above the upper one. Within one mains period of 50 Hz or 60 Hz, edges are roughly 8.3 to 10 ms apart. The block runs from a 24 MHz crystal clock and first passes the raw bit through a two-stage synchronizer.

The filter is deliberately asymmetric. A low-to-high change of the synchronized input reaches the output on the next clock, and a one-cycle strobe marks it as the zero-crossing event. A high-to-low change is accepted only after the input has stayed low across two consecutive boundaries of a free-running 0.5 ms tick, so the delay falls between 0.5 ms and 1 ms. Any return to high during that time discards the partial qualification.

Top module: `zc_fall_debounce`

## Requirements
- R1: A synchronous reset, whether at start-up or in the middle of operation, forces `filt_out` and `rise_stb` to 0 on the clock edges where `rst` is high.
- R2: When `raw_in` goes high while `filt_out` is low, `filt_out` goes high on the third rising clock edge after the change. Two of those edges are the synchronizer and one is the output register.
- R3: `rise_stb` is high for exactly one cycle, in the cycle in which `filt_out` changes from 0 to 1, and it is low at all other times.
- R4: The tick prescaler runs freely from reset, and a tick falls on the clock edges numbered TICK_DIV, 2*TICK_DIV, and so on after reset is released. `filt_out` falls at the QUAL_TICKS-th tick edge at which the synchronized input has been seen low without interruption.
- R5: With QUAL_TICKS = 2, a falling edge of the synchronized input reaches `filt_out` between TICK_DIV+1 and 2*TICK_DIV clocks later. At the default of 12000 clocks at 24 MHz, this is 0.5 to 1 ms.
- R6: A low pulse on `raw_in` that is shorter than the minimum acceptance delay leaves `filt_out` at 1 and produces no `rise_stb`.
- R7: A return of the synchronized input to high clears the qualification. Repeated low stretches of TICK_DIV cycles, each separated by a single high cycle, never bring `filt_out` low.
- R8: A single-cycle high pulse on `raw_in` while `filt_out` is low raises `filt_out` and fires `rise_stb`. After that, `filt_out` needs a full new qualification before it falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Asynchronous comparator output |
| filt_out | output | 1 | Debounced zero-crossing level |
| rise_stb | output | 1 | One-cycle pulse on each accepted rising edge |

## Verification
The bench shrinks the tick period to a few clocks. It then sweeps the position of the falling edge across two full tick periods and checks the exact commit cycle predicted from the tick grid. A prescaler that restarted on each edge, or a commit that came one tick early or late, would land on the wrong cycle. A separate sweep applies every short low pulse length and checks that the output never drops. A train of low stretches, each one tick long and broken by single high cycles, shows that a design that kept counting across the breaks would commit. Single-cycle high glitches show whether rising edges really pass unfiltered and whether they restart the qualification.

// File: rtl/zc_fall_debounce.sv
module zc_fall_debounce #(
  parameter int TICK_DIV    = 12000,
  parameter int QUAL_TICKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic filt_out,
  output logic rise_stb
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int QW = $clog2(QUAL_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [PW-1:0]          pre_q;
  logic [QW-1:0]          qual_q;

  wire s_in      = sync_q[SYNC_STAGES-1];
  wire tick      = (pre_q == PW'(TICK_DIV - 1));
  wire last_tick = tick && (qual_q == QW'(QUAL_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
  end

  always_ff @(posedge clk) begin
    if (rst || tick) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_out <= 1'b0;
      qual_q   <= '0;
      rise_stb <= 1'b0;
    end else begin
      rise_stb <= s_in & ~filt_out;
      if (s_in) begin
        filt_out <= 1'b1;
        qual_q   <= '0;
      end else if (!filt_out) begin
        qual_q   <= '0;
      end else if (last_tick) begin
        filt_out <= 1'b0;
        qual_q   <= '0;
      end else if (tick) begin
        qual_q   <= qual_q + 1'b1;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !filt_out && !rise_stb); // R1
  AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) s_in |=> filt_out); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) rise_stb |=> !rise_stb); // R3
  AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (rst) rise_stb |-> filt_out && !$past(filt_out)); // R3
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst) $fell(filt_out) |-> !$past(s_in) && $past(tick)); // R4
  AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (rst) qual_q < QW'(QUAL_TICKS)); // R7
endmodule

// File: tb/zc_fall_debounce_tb_top.sv
module zc_fall_debounce_tb_top;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_in = 1'b0;
  logic filt_out, rise_stb;
  int   n_chk = 0, n_fail = 0, edges = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  zc_fall_debounce #(.TICK_DIV(DIV), .QUAL_TICKS(2), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .raw_in(raw_in), .filt_out(filt_out), .rise_stb(rise_stb));

  always @(posedge clk) begin
    edges <= edges + 1;
    if (edges > 60000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cyc(3);
    chk(filt_out == 1'b0, "R1 filt_out", filt_out, 0);
    chk(rise_stb == 1'b0, "R1 rise_stb", rise_stb, 0);
    rst = 1'b0;
  endtask

  task automatic fall_measure(output int n);
    n = 0;
    raw_in = 1'b0;
    while (filt_out && n < 4 * DIV) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n, m, j1, stb_seen, ok;
    bit hit[DIV];
    cyc(2);
    chk(filt_out == 1'b0 && rise_stb == 1'b0, "R1 reset state", {filt_out, rise_stb}, 0);
    rst = 1'b0;

    // R2 R3: rising latency and strobe
    cyc(4);
    raw_in = 1'b1;
    cyc(2);
    chk(filt_out == 1'b0, "R2 not yet high after 2 edges", filt_out, 0);
    chk(rise_stb == 1'b0, "R3 strobe early", rise_stb, 0);
    cyc(1);
    chk(filt_out == 1'b1, "R2 high after 3 edges", filt_out, 1);
    chk(rise_stb == 1'b1, "R3 strobe with rise", rise_stb, 1);
    cyc(1);
    chk(rise_stb == 1'b0, "R3 strobe one cycle", rise_stb, 0);

    // R4 R5: exact commit cycle on tick grid, swept over phases
    for (int ph = 0; ph < 2 * DIV; ph++) begin
      raw_in = 1'b1;
      do_reset();
      m = 4 + ph;
      cyc(m);
      j1 = ((m + 3 + DIV - 1) / DIV) * DIV;
      fall_measure(n);
      chk(n == j1 + DIV - m, "R4 commit edge", n, j1 + DIV - m);
      chk(n >= DIV + 3 && n <= 2 * DIV + 2, "R5 window", n, DIV + 3);
      if (n >= DIV + 3 && n <= 2 * DIV + 2) hit[n - DIV - 3] = 1'b1;
    end
    ok = 1;
    for (int k = 0; k < DIV; k++) if (!hit[k]) ok = 0;
    chk(ok == 1, "R5 every delay in window reached", ok, 1);

    // R6: short low pulses ignored
    raw_in = 1'b1;
    cyc(DIV * 3);
    for (int len = 1; len <= DIV; len++) begin
      stb_seen = 0; ok = 1;
      raw_in = 1'b0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (!filt_out) ok = 0;
        if (rise_stb) stb_seen = 1;
      end
      raw_in = 1'b1;
      for (int i = 0; i < 2 * DIV + 4; i++) begin
        @(negedge clk);
        if (!filt_out) ok = 0;
        if (rise_stb) stb_seen = 1;
      end
      chk(ok == 1, "R6 short low kept high", ok, 1);
      chk(stb_seen == 0, "R6 no strobe", stb_seen, 0);
    end

    // R7: qualification cleared by return high
    ok = 1; stb_seen = 0;
    for (int r = 0; r < 10; r++) begin
      raw_in = 1'b0;
      for (int i = 0; i < DIV; i++) begin
        @(negedge clk);
        if (!filt_out) ok = 0;
        if (rise_stb) stb_seen = 1;
      end
      raw_in = 1'b1;
      @(negedge clk);
      if (!filt_out) ok = 0;
      if (rise_stb) stb_seen = 1;
    end
    cyc(4);
    chk(ok == 1 && filt_out == 1'b1, "R7 never committed", ok, 1);
    chk(stb_seen == 0, "R7 no strobe", stb_seen, 0);

    // R8: high glitch while low passes through, then requalifies
    fall_measure(n);
    chk(filt_out == 1'b0, "R8 low before glitch", filt_out, 0);
    cyc(3);
    raw_in = 1'b1;
    @(negedge clk);
    raw_in = 1'b0;
    cyc(2);
    chk(filt_out == 1'b1, "R8 glitch raised output", filt_out, 1);
    chk(rise_stb == 1'b1, "R8 glitch strobe", rise_stb, 1);
    n = 0;
    while (filt_out && n < 4 * DIV) begin
      @(negedge clk); n++;
    end
    chk(n >= DIV && n <= 2 * DIV, "R8 full requalification", n, DIV);

    // R1: reset mid-run while high
    raw_in = 1'b1;
    cyc(5);
    chk(filt_out == 1'b1, "R2 high before reset", filt_out, 1);
    do_reset();
    cyc(3);
    chk(filt_out == 1'b1 && rise_stb == 1'b1, "R3 strobe after reset", {filt_out, rise_stb}, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule